// File: doc/BRIEF.md
# Sequential Booth Signed Multiplier

This block multiplies two signed two's-complement operands of `WIDTH` bits. It spends one clock cycle per multiplier bit and uses radix-2 Booth recoding. A start pulse captures both operands. The multiplicand goes into a register `M`, and the multiplier goes into a shift register `Q` that has an extra guard bit to the right of its least significant bit. The accumulator is cleared at the same time.

Each step looks at the low bit of `Q` together with the guard bit. From that pair it adds `M`, subtracts `M`, or leaves the accumulator alone. The combined accumulator, `Q` and guard bit then shift right by one place, and the shift copies the sign bit of the accumulator. Because of this recoding, negative and positive operands follow the same sequence, and no sign correction is applied at the end.

The accumulator carries one bit more than the operands. This allows the most negative multiplicand to be subtracted without wrapping. The double-width result is read from the low `WIDTH` bits of the accumulator followed by `Q`.

Top module: `booth_seq_mult`

## Requirements
- R1: While `rst` is high at a rising clock edge, the block goes idle: `busy` = 0, `done` = 0 and `product` = 0 after that edge.
- R2: When `start` is high at a rising edge while `busy` is 0, the operands are captured at that edge. `busy` is 1 for exactly `WIDTH` cycles after that edge.
- R3: `done` is 1 for exactly one cycle. That cycle follows the `WIDTH`-th edge after the accepted start, and it is the first cycle in which `busy` has returned to 0.
- R4: When `done` is 1, `product` (2·`WIDTH` bits, two's complement) equals the signed product of the captured operands, whatever the signs of the operands.
- R5: Extreme operands give exact results. The most negative multiplicand and multiplier are included, for example -128 × -128 = 16384 for `WIDTH` = 8.
- R6: A `start` pulse while `busy` is 1 is ignored. The running operation keeps its operands, its timing and its result.
- R7: After `done`, `product` holds its value while no new start is accepted, even when the operand inputs change.
- R8: A zero operand in either position gives a zero product.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a multiplication when the block is idle |
| mcand | input | WIDTH | Signed multiplicand, captured on an accepted start |
| mplier | input | WIDTH | Signed multiplier, captured on an accepted start |
| busy | output | 1 | High while the Booth steps are running |
| done | output | 1 | One-cycle pulse when the product is ready |
| product | output | 2*WIDTH | Signed product |

## Verification
Call the edge that accepts `start` edge 0. The bench expects `busy` to read 1 after edge 0 and after each edge up to and including edge `WIDTH`-1. After edge `WIDTH`, it expects `done` to be 1, `busy` to be 0 and the product to be correct. After the edge that follows, it expects `done` to be 0 again.

Every sample is taken on the falling clock edge, so each cycle's count can be checked exactly. The expected product comes from a signed multiply in the bench, which is independent of the step logic. A start injected partway through a run must leave all of these cycle positions unchanged.

// File: rtl/booth_pkg.sv
package booth_pkg;

    // Action chosen for one Booth step
    typedef enum logic [1:0] {
        STEP_SHIFT = 2'b00,
        STEP_ADD   = 2'b01,
        STEP_SUB   = 2'b10
    } step_e;

    // Control outputs of the sequencer
    typedef struct packed {
        logic busy;
        logic done;
        logic load;
        logic step;
    } ctrl_s;

    // Recode the pair {low multiplier bit, guard bit}
    function automatic step_e booth_recode(input logic q_lsb, input logic q_guard);
        step_e r;
        case ({q_lsb, q_guard})
            2'b10:   r = STEP_SUB;
            2'b01:   r = STEP_ADD;
            default: r = STEP_SHIFT;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/booth_recoder.sv
module booth_recoder
    import booth_pkg::*;
(
    input  logic  q_lsb,
    input  logic  q_guard,
    output step_e step
);

    always_comb begin
        step = booth_recode(q_lsb, q_guard);
    end

endmodule

// File: rtl/booth_addsub.sv
module booth_addsub
    import booth_pkg::*;
#(
    parameter int W = 9
) (
    input  logic [W-1:0] acc_in,
    input  logic [W-1:0] m_in,
    input  step_e        step,
    output logic [W-1:0] acc_out
);

    logic         do_sub;
    logic         do_op;
    logic [W-1:0] m_eff;
    logic [W:0]   carry;
    logic [W-1:0] sum;

    assign do_sub   = (step == STEP_SUB);
    assign do_op    = (step != STEP_SHIFT);
    assign m_eff    = do_sub ? ~m_in : m_in;
    assign carry[0] = do_sub;

    // Ripple chain of full adders
    for (genvar i = 0; i < W; i++) begin : g_fa
        assign sum[i]     = acc_in[i] ^ m_eff[i] ^ carry[i];
        assign carry[i+1] = (acc_in[i] & m_eff[i]) | (carry[i] & (acc_in[i] ^ m_eff[i]));
    end

    assign acc_out = do_op ? sum : acc_in;

    // Shift-only steps pass the accumulator through unchanged
    always_comb begin
        if (step == STEP_SHIFT) begin
            a_r4_shift_only_passes: assert (acc_out == acc_in);
        end
    end

endmodule

// File: rtl/booth_shifter.sv
module booth_shifter #(
    parameter int AW = 9,
    parameter int QW = 8
) (
    input  logic [AW-1:0] a_in,
    input  logic [QW-1:0] q_in,
    input  logic          g_in,
    output logic [AW-1:0] a_out,
    output logic [QW-1:0] q_out,
    output logic          g_out
);

    assign a_out = {a_in[AW-1], a_in[AW-1:1]};
    assign q_out = {a_in[0], q_in[QW-1:1]};
    assign g_out = q_in[0];

endmodule

// File: rtl/booth_ctrl.sv
module booth_ctrl
    import booth_pkg::*;
#(
    parameter int N = 8
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  start,
    output ctrl_s ctrl
);

    localparam int CW = $clog2(N + 1);
    localparam logic [CW-1:0] LAST = CW'(N - 1);

    logic          busy_q;
    logic          done_q;
    logic [CW-1:0] cnt_q;
    logic          load;

    assign load = start && !busy_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            done_q <= 1'b0;
            cnt_q  <= '0;
        end else begin
            done_q <= 1'b0;
            if (load) begin
                busy_q <= 1'b1;
                cnt_q  <= '0;
            end else if (busy_q) begin
                if (cnt_q == LAST) begin
                    busy_q <= 1'b0;
                    done_q <= 1'b1;
                end
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign ctrl.busy = busy_q;
    assign ctrl.done = done_q;
    assign ctrl.load = load;
    assign ctrl.step = busy_q;

    // R2: step counter never passes the last step while running
    a_r2_count_in_range: assert property (@(posedge clk) disable iff (rst)
        busy_q |-> (cnt_q < CW'(N)));

    // R3: done lasts a single cycle
    a_r3_done_one_cycle: assert property (@(posedge clk) disable iff (rst)
        done_q |=> !done_q);

    // R3: done appears only as busy ends
    a_r3_done_ends_busy: assert property (@(posedge clk) disable iff (rst)
        done_q |-> ($past(busy_q) && !busy_q));

    // R6: a start while running does not restart the count
    a_r6_no_restart: assert property (@(posedge clk) disable iff (rst)
        (busy_q && start) |=> (cnt_q != '0));

endmodule

// File: rtl/booth_seq_mult.sv
module booth_seq_mult
    import booth_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  logic [WIDTH-1:0]   mcand,
    input  logic [WIDTH-1:0]   mplier,
    output logic               busy,
    output logic               done,
    output logic [2*WIDTH-1:0] product
);

    localparam int AW = WIDTH + 1;

    ctrl_s            ctrl;
    step_e            step;
    logic [AW-1:0]    acc_q;
    logic [AW-1:0]    m_q;
    logic [WIDTH-1:0] q_q;
    logic             guard_q;
    logic [AW-1:0]    acc_sum;
    logic [AW-1:0]    acc_sh;
    logic [WIDTH-1:0] q_sh;
    logic             guard_sh;

    booth_ctrl #(.N(WIDTH)) u_ctrl (
        .clk   (clk),
        .rst   (rst),
        .start (start),
        .ctrl  (ctrl)
    );

    booth_recoder u_recoder (
        .q_lsb   (q_q[0]),
        .q_guard (guard_q),
        .step    (step)
    );

    booth_addsub #(.W(AW)) u_addsub (
        .acc_in  (acc_q),
        .m_in    (m_q),
        .step    (step),
        .acc_out (acc_sum)
    );

    booth_shifter #(.AW(AW), .QW(WIDTH)) u_shifter (
        .a_in  (acc_sum),
        .q_in  (q_q),
        .g_in  (guard_q),
        .a_out (acc_sh),
        .q_out (q_sh),
        .g_out (guard_sh)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q   <= '0;
            m_q     <= '0;
            q_q     <= '0;
            guard_q <= 1'b0;
        end else if (ctrl.load) begin
            acc_q   <= '0;
            m_q     <= {mcand[WIDTH-1], mcand};
            q_q     <= mplier;
            guard_q <= 1'b0;
        end else if (ctrl.step) begin
            acc_q   <= acc_sh;
            q_q     <= q_sh;
            guard_q <= guard_sh;
        end
    end

    assign busy    = ctrl.busy;
    assign done    = ctrl.done;
    assign product = {acc_q[WIDTH-1:0], q_q};

    // R5: after each shift the accumulator fits in WIDTH bits
    a_r5_acc_fits: assert property (@(posedge clk) disable iff (rst)
        (busy || done) |-> (acc_q[AW-1] == acc_q[AW-2]));

    // R6: multiplicand stays fixed during a run
    a_r6_mcand_kept: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(m_q));

    // R7: result held while idle and no start
    a_r7_product_held: assert property (@(posedge clk) disable iff (rst)
        (!busy && !start) |=> $stable(product));

endmodule

// File: tb/test_booth_seq_mult.sv
module test_booth_seq_mult;

    localparam int W = 8;

    logic           clk = 1'b0;
    logic           rst;
    logic           start;
    logic [W-1:0]   mcand;
    logic [W-1:0]   mplier;
    logic           busy;
    logic           done;
    logic [2*W-1:0] product;

    int n_checks = 0;
    int n_fail   = 0;

    always #10 clk = ~clk;

    booth_seq_mult #(.WIDTH(W)) i_booth_seq_mult (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .mcand   (mcand),
        .mplier  (mplier),
        .busy    (busy),
        .done    (done),
        .product (product)
    );

    function automatic longint ref_mul(input logic [W-1:0] a, input logic [W-1:0] b);
        longint sa;
        longint sb;
        sa = longint'($signed(a));
        sb = longint'($signed(b));
        return sa * sb;
    endfunction

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic longint prod_val();
        return longint'($signed(product));
    endfunction

    // Drives one operation from a falling edge and checks every cycle of it
    task automatic run_op(input logic [W-1:0] a, input logic [W-1:0] b,
                          input string tag, input bit interfere);
        longint exp;
        exp    = ref_mul(a, b);
        mcand  = a;
        mplier = b;
        start  = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(busy == 1'b1, "R2 busy after start", busy, 1);
        for (int i = 1; i < W; i++) begin
            if (interfere && i == 2) begin
                mcand  = ~a;
                mplier = b ^ 8'h5a;
                start  = 1'b1;
            end
            @(negedge clk);
            start = 1'b0;
            check(busy == 1'b1, "R2 busy during run", busy, 1);
            check(done == 1'b0, "R3 done early", done, 0);
        end
        @(negedge clk);
        check(done == 1'b1, "R3 done at step count", done, 1);
        check(busy == 1'b0, "R2 busy dropped", busy, 0);
        check(prod_val() == exp, tag, prod_val(), exp);
        @(negedge clk);
        check(done == 1'b0, "R3 done single cycle", done, 0);
        check(prod_val() == exp, "R7 product held", prod_val(), exp);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        longint held;
        rst    = 1'b1;
        start  = 1'b0;
        mcand  = '0;
        mplier = '0;
        repeat (3) @(negedge clk);
        // R1: reset state
        check(busy == 1'b0, "R1 busy in reset", busy, 0);
        check(done == 1'b0, "R1 done in reset", done, 0);
        check(product == '0, "R1 product in reset", prod_val(), 0);
        rst = 1'b0;
        @(negedge clk);

        // R4: sign combinations
        run_op(8'd11, 8'd13, "R4 pos*pos", 1'b0);
        run_op(8'd11, -8'sd13, "R4 pos*neg", 1'b0);
        run_op(-8'sd11, 8'd13, "R4 neg*pos", 1'b0);
        run_op(-8'sd11, -8'sd13, "R4 neg*neg", 1'b0);

        // R5: extremes
        run_op(8'h80, 8'h80, "R5 min*min", 1'b0);
        run_op(8'h80, 8'h7f, "R5 min*max", 1'b0);
        run_op(8'h7f, 8'h80, "R5 max*min", 1'b0);
        run_op(8'h80, 8'h01, "R5 min*one", 1'b0);
        run_op(8'h80, 8'hff, "R5 min*minus1", 1'b0);
        run_op(8'h7f, 8'h7f, "R5 max*max", 1'b0);
        run_op(8'hff, 8'hff, "R5 minus1*minus1", 1'b0);

        // R8: zero operands
        run_op(8'h00, 8'hfb, "R8 zero mcand", 1'b0);
        run_op(8'd37, 8'h00, "R8 zero mplier", 1'b0);

        // R6: start during a run is ignored
        run_op(8'd91, -8'sd77, "R6 result with mid-run start", 1'b1);
        run_op(8'h80, 8'h55, "R6 result with mid-run start", 1'b1);

        // R7: hold while inputs change and no start
        held   = prod_val();
        mcand  = 8'h3c;
        mplier = 8'hc3;
        repeat (5) @(negedge clk);
        check(prod_val() == held, "R7 hold with changing inputs", prod_val(), held);
        check(done == 1'b0, "R3 no done while idle", done, 0);

        // R4: random operands with fixed seed
        void'($urandom(32'd20250611));
        for (int k = 0; k < 150; k++) begin
            logic [W-1:0] ra;
            logic [W-1:0] rb;
            ra = W'($urandom);
            rb = W'($urandom);
            run_op(ra, rb, "R4 random", (k % 7) == 3);
        end

        // R1: reset mid-run clears the block
        mcand  = 8'd5;
        mplier = 8'd9;
        start  = 1'b1;
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check(busy == 1'b0, "R1 busy after reset", busy, 0);
        check(product == '0, "R1 product after reset", prod_val(), 0);
        rst = 1'b0;
        @(negedge clk);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule